// File: doc/BRIEF.md
# Event-Synchronized Timestamp Capture Unit

This block keeps a free-running timestamp for an event-link receiver and hands a snapshot of it to software whenever a trigger channel fires. The count advances on one of two tick sources chosen by configuration. The first is a decoded event code that matches a programmable tick code. The second is a divided carrier: the link delivers one enable pulse per carrier period, and every tenth pulse is one tick, which turns a 10 MHz carrier into 1 MHz. A second programmable event code acts as the sync event. It returns the count to zero, restarts the carrier divider phase and raises a one-cycle sync flag.

Any of the trigger inputs copies the count into a holding register. Software reads that register at leisure and acknowledges the read with a strobe. Captures from all channels share a single interrupt enable, and each capture then produces a one-cycle interrupt request. A sticky overrun flag shows that a second capture replaced a value the host had not yet acknowledged. Rate limiting of interrupts is left to the system around the block.

Top module: `ts_capture_unit`

## Requirements
- R1: After a synchronous active-low reset, `ts_held`, `sync_flag`, `irq` and `overrun` are all 0, and the internal count and divider phase are 0.
- R2: With `cfg_tick_src`=0 (event mode), each cycle with `ev_valid`=1 and `ev_code`==`cfg_tick_code` advances the count by exactly 1 at that clock edge. Other codes and carrier pulses leave the count unchanged.
- R3: With `cfg_tick_src`=1 (carrier mode), the count advances once for every DIV (default 10) cycles with `carrier_en`=1, on the edge of the DIV-th pulse. Matching tick-code events are ignored in this mode.
- R4: A cycle with `ev_valid`=1 and `ev_code`==`cfg_sync_code` sets the count to 0 at that edge. If a tick arrives in the same cycle, the clear wins.
- R5: `sync_flag` is high for exactly the one cycle that follows each sync event, and is low at all other times.
- R6: A cycle with any bit of `trig` high loads `ts_held` with the count as it stood before that edge, which is the value before any clear or advance taking effect at that edge. Without a trigger, `ts_held` does not change.
- R7: The count wraps from all ones to zero and does not saturate.
- R8: `irq` is high for the one cycle after a capture only if `cfg_irq_en` was 1 in the capture cycle. Several trigger bits in the same cycle give a single pulse.
- R9: `overrun` is set when a capture occurs while the previous capture is still unacknowledged. A cycle with `rd_ack`=1 clears it. If a capture and `rd_ack` occur in the same cycle, the acknowledge applies to the old value and `overrun` is cleared.
- R10: A sync event also restarts the carrier divider, so the next carrier-mode tick comes on the DIV-th `carrier_en` pulse after the sync cycle.
- R11: Event inputs are ignored while `ev_valid`=0, whatever the value on `ev_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event code strobe |
| ev_code | input | CODE_W (8) | Received event code |
| carrier_en | input | 1 | One pulse per link carrier period |
| cfg_tick_src | input | 1 | Tick source: 0 event code, 1 divided carrier |
| cfg_tick_code | input | CODE_W (8) | Event code that advances the count in event mode |
| cfg_sync_code | input | CODE_W (8) | Event code that clears the count |
| cfg_irq_en | input | 1 | Shared interrupt enable for captures |
| trig | input | NUM_CH (4) | Per-channel capture strobes |
| rd_ack | input | 1 | Host acknowledges reading `ts_held` |
| ts_held | output | TS_W (32) | Last captured timestamp |
| sync_flag | output | 1 | One-cycle pulse after a sync event |
| irq | output | 1 | One-cycle capture interrupt request |
| overrun | output | 1 | Sticky flag for an unacknowledged capture that was replaced |

## Verification
The count and the divider phase are internal, so a fault in either can only be seen through `ts_held`. It appears at the next capture as a value that is off by a fixed amount, such as a missed tick, an extra tick or a clear that did not happen. The divider phase shows only in carrier mode, where the capture comes out one tick early or late after a sync. Faults in the flags are seen one cycle after the cause: `sync_flag`, `irq` and `overrun` are all registered, and each can be compared in every cycle against a model that tracks the captures that have not been acknowledged.

// File: rtl/ts_pkg.sv
// Shared types for the timestamp capture unit.
package ts_pkg;
    // Source of the counter advance tick.
    typedef enum logic {
        TICK_EVENT   = 1'b0,
        TICK_CARRIER = 1'b1
    } tick_src_e;
endpackage

// File: rtl/ts_tick_gen.sv
// Decodes the event stream into a tick pulse and a sync hit.
// In carrier mode the tick is every DIV-th carrier_en pulse. The divider
// phase restarts on a sync hit. Assumes DIV >= 2. Both outputs are
// combinational and valid in the same cycle as their inputs.
module ts_tick_gen #(
    parameter int CODE_W = 8,
    parameter int DIV    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              carrier_en,
    input  ts_pkg::tick_src_e tick_src,
    input  logic [CODE_W-1:0] tick_code,
    input  logic [CODE_W-1:0] sync_code,
    output logic              tick,
    output logic              sync_hit
);
    localparam int PRE_W = $clog2(DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             pre_wrap;
    logic             ev_tick;

    // Decode the matches for the sync code and the tick code.
    always_comb begin
        sync_hit = ev_valid && (ev_code == sync_code);
        ev_tick  = ev_valid && (ev_code == tick_code);
        pre_wrap = carrier_en && (pre_q == PRE_LAST);
        tick     = (tick_src == ts_pkg::TICK_CARRIER) ? pre_wrap : ev_tick;
    end

    // Carrier divider, restarted by a sync hit.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_hit)
            pre_q <= '0;
        else if (carrier_en)
            pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/ts_counter.sv
// Wrapping timestamp counter. A clear has priority over an advance.
module ts_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            clear,
    output logic [TS_W-1:0] count
);
    // Advance by one on a tick or clear on sync, wrapping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (tick)
            count <= count + TS_W'(1);
    end
endmodule

// File: rtl/ts_capture.sv
// Holds the snapshot of the count and produces the host-facing flags.
// A capture takes the count before this edge's update. Every flag is
// registered and so appears one cycle after its cause.
module ts_capture #(
    parameter int TS_W   = 32,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] trig,
    input  logic [TS_W-1:0]   count,
    input  logic              rd_ack,
    input  logic              irq_en,
    input  logic              sync_hit,
    output logic [TS_W-1:0]   held,
    output logic              irq,
    output logic              overrun,
    output logic              sync_flag
);
    logic cap;
    logic unread_q;

    // Any channel trigger is a capture.
    always_comb cap = |trig;

    // Holding register for the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (cap)
            held <= count;
    end

    // Track unacknowledged captures and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unread_q <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (cap)
                unread_q <= 1'b1;
            else if (rd_ack)
                unread_q <= 1'b0;
            if (cap && unread_q && !rd_ack)
                overrun <= 1'b1;
            else if (rd_ack)
                overrun <= 1'b0;
        end
    end

    // One-cycle interrupt and sync pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            sync_flag <= 1'b0;
        end else begin
            irq       <= cap && irq_en;
            sync_flag <= sync_hit;
        end
    end
endmodule

// File: rtl/ts_capture_unit.sv
// Top of the timestamp capture unit. It connects the tick decoder, the
// wrapping counter and the capture stage. Assumes the event strobes and
// carrier_en are already synchronous to clk.
module ts_capture_unit #(
    parameter int TS_W   = 32,
    parameter int CODE_W = 8,
    parameter int NUM_CH = 4,
    parameter int DIV    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              carrier_en,
    input  logic              cfg_tick_src,
    input  logic [CODE_W-1:0] cfg_tick_code,
    input  logic [CODE_W-1:0] cfg_sync_code,
    input  logic              cfg_irq_en,
    input  logic [NUM_CH-1:0] trig,
    input  logic              rd_ack,
    output logic [TS_W-1:0]   ts_held,
    output logic              sync_flag,
    output logic              irq,
    output logic              overrun
);
    logic            tick_w;
    logic            sync_w;
    logic [TS_W-1:0] ts_count;
    ts_pkg::tick_src_e src_w;

    // Map the configuration bit onto the tick source type.
    always_comb src_w = ts_pkg::tick_src_e'(cfg_tick_src);

    ts_tick_gen #(.CODE_W(CODE_W), .DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .carrier_en(carrier_en), .tick_src(src_w), .tick_code(cfg_tick_code),
        .sync_code(cfg_sync_code), .tick(tick_w), .sync_hit(sync_w)
    );

    ts_counter #(.TS_W(TS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .clear(sync_w), .count(ts_count)
    );

    ts_capture #(.TS_W(TS_W), .NUM_CH(NUM_CH)) u_cap (
        .clk(clk), .rst_n(rst_n), .trig(trig), .count(ts_count), .rd_ack(rd_ack),
        .irq_en(cfg_irq_en), .sync_hit(sync_w), .held(ts_held), .irq(irq),
        .overrun(overrun), .sync_flag(sync_flag)
    );
endmodule

// File: rtl/ts_capture_sva.sv
// Temporal checks for ts_capture_unit, attached to every instance by bind.
module ts_capture_sva #(
    parameter int TS_W   = 32,
    parameter int CODE_W = 8,
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [CODE_W-1:0] ev_code,
    input logic [CODE_W-1:0] cfg_sync_code,
    input logic              cfg_irq_en,
    input logic [NUM_CH-1:0] trig,
    input logic              rd_ack,
    input logic [TS_W-1:0]   ts_held,
    input logic              sync_flag,
    input logic              irq,
    input logic              overrun,
    input logic              tick_w,
    input logic              sync_w,
    input logic [TS_W-1:0]   ts_count
);
    p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_w && !sync_w) |=> ts_count == $past(ts_count) + TS_W'(1));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_code == cfg_sync_code) |=> ts_count == '0);

    p_sync_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_code == cfg_sync_code) |=> sync_flag);

    p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == '0) |=> $stable(ts_held));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_w && !sync_w && ts_count == '1) |=> ts_count == '0);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq |-> $past(cfg_irq_en) && $past(trig) != '0));

    p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !overrun);
endmodule

bind ts_capture_unit ts_capture_sva #(.TS_W(TS_W), .CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_sva (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .cfg_sync_code(cfg_sync_code), .cfg_irq_en(cfg_irq_en), .trig(trig),
    .rd_ack(rd_ack), .ts_held(ts_held), .sync_flag(sync_flag), .irq(irq),
    .overrun(overrun), .tick_w(tick_w), .sync_w(sync_w), .ts_count(ts_count)
);

// File: tb/tb_ts_capture_unit.sv
module tb_ts_capture_unit;
    localparam int DIV = 10;
    localparam logic [7:0] TCODE = 8'h21;
    localparam logic [7:0] SCODE = 8'h7E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0;
    logic [7:0] ev_code = 8'h00;
    logic carrier_en = 1'b0;
    logic cfg_tick_src = 1'b0;
    logic cfg_irq_en = 1'b0;
    logic [3:0] trig = 4'h0;
    logic rd_ack = 1'b0;
    logic [31:0] ts_held;
    logic sync_flag, irq, overrun;
    logic [7:0] held_n;
    logic sync_n, irq_n, ovr_n;

    int checks = 0;
    int fails = 0;

    // Model state
    logic [31:0] m_cnt = 0, m_held = 0;
    logic [7:0]  m_cnt8 = 0, m_held8 = 0;
    int m_pre = 0;
    logic m_unread = 0, m_ovr = 0, m_irq = 0, m_sync = 0;

    always #5 clk = ~clk;

    ts_capture_unit dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .carrier_en(carrier_en), .cfg_tick_src(cfg_tick_src), .cfg_tick_code(TCODE),
        .cfg_sync_code(SCODE), .cfg_irq_en(cfg_irq_en), .trig(trig), .rd_ack(rd_ack),
        .ts_held(ts_held), .sync_flag(sync_flag), .irq(irq), .overrun(overrun)
    );

    ts_capture_unit #(.TS_W(8)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .carrier_en(carrier_en), .cfg_tick_src(cfg_tick_src), .cfg_tick_code(TCODE),
        .cfg_sync_code(SCODE), .cfg_irq_en(cfg_irq_en), .trig(trig), .rd_ack(rd_ack),
        .ts_held(held_n), .sync_flag(sync_n), .irq(irq_n), .overrun(ovr_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Next-state model derived from the requirements.
    task automatic model_step();
        logic sy, tk, cp;
        sy = ev_valid && (ev_code == SCODE);
        tk = cfg_tick_src ? (carrier_en && m_pre == DIV - 1)
                          : (ev_valid && ev_code == TCODE);
        cp = (trig != 4'h0);
        if (cp) begin m_held = m_cnt; m_held8 = m_cnt8; end
        if (sy) begin m_cnt = 0; m_cnt8 = 0; end
        else if (tk) begin m_cnt = m_cnt + 1; m_cnt8 = m_cnt8 + 1; end
        if (sy) m_pre = 0;
        else if (carrier_en) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
        m_ovr = (cp && m_unread && !rd_ack) ? 1'b1 : (rd_ack ? 1'b0 : m_ovr);
        m_unread = cp ? 1'b1 : (rd_ack ? 1'b0 : m_unread);
        m_irq = cp && cfg_irq_en;
        m_sync = sy;
    endtask

    // One clock: update the model at the edge, compare after it, idle the inputs.
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        check("R6 held", ts_held, m_held);
        check("R7 narrow held", {24'h0, held_n}, {24'h0, m_held8});
        check("R5 sync_flag", {31'h0, sync_flag}, {31'h0, m_sync});
        check("R8 irq", {31'h0, irq}, {31'h0, m_irq});
        check("R9 overrun", {31'h0, overrun}, {31'h0, m_ovr});
        @(negedge clk);
        ev_valid = 0; ev_code = 8'h00; carrier_en = 0; trig = 0; rd_ack = 0;
    endtask

    task automatic ev(input logic [7:0] c);
        ev_valid = 1; ev_code = c; cyc();
    endtask

    task automatic cap_ack();
        trig = 4'b0001; rd_ack = 1; cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1 held", ts_held, 32'h0);
        check("R1 flags", {29'h0, sync_flag, irq, overrun}, 32'h0);

        // R2: event-mode advance
        cfg_irq_en = 1;
        ev(SCODE);
        repeat (5) ev(TCODE);
        ev(8'h33); carrier_en = 1; cyc();
        cap_ack();
        check("R2 five ticks", ts_held, 32'd5);

        // R11: strobe low ignores matching codes
        ev_valid = 0; ev_code = TCODE; cyc();
        ev_valid = 0; ev_code = SCODE; cyc();
        cap_ack();
        check("R11 no strobe", ts_held, 32'd5);

        // R4: clear beats nothing, capture sees pre-clear value (R6)
        ev_valid = 1; ev_code = SCODE; trig = 4'b1010; rd_ack = 1; cyc();
        check("R6 pre-clear capture", ts_held, 32'd5);
        cap_ack();
        check("R4 cleared", ts_held, 32'd0);

        // R3: carrier mode, tick codes ignored
        cfg_tick_src = 1;
        ev(SCODE);
        for (int i = 0; i < 25; i++) begin
            carrier_en = 1; ev_valid = 1; ev_code = TCODE; cyc();
        end
        cap_ack();
        check("R3 carrier div", ts_held, 32'd2);

        // R10: sync restarts divider phase
        repeat (7) begin carrier_en = 1; cyc(); end
        ev(SCODE);
        repeat (9) begin carrier_en = 1; cyc(); end
        cap_ack();
        check("R10 phase nine", ts_held, 32'd0);
        carrier_en = 1; cyc();
        cap_ack();
        check("R10 phase ten", ts_held, 32'd1);

        // R4: clear wins over a same-cycle carrier tick
        repeat (9) begin carrier_en = 1; cyc(); end
        carrier_en = 1; ev_valid = 1; ev_code = SCODE; cyc();
        cap_ack();
        check("R4 clear wins", ts_held, 32'd0);

        // R7: wrap of the narrow instance
        cfg_tick_src = 0;
        ev(SCODE);
        repeat (300) ev(TCODE);
        cap_ack();
        check("R7 wide", ts_held, 32'd300);
        check("R7 wrap", {24'h0, held_n}, 32'd44);

        // R9: overrun set then cleared; R8 irq gated off
        cfg_irq_en = 0;
        trig = 4'b0100; cyc();
        trig = 4'b0100; cyc();
        check("R9 overrun set", {31'h0, overrun}, 32'd1);
        check("R8 irq disabled", {31'h0, irq}, 32'd0);
        rd_ack = 1; cyc();
        check("R9 overrun clear", {31'h0, overrun}, 32'd0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            if (i % 250 == 0) cfg_tick_src = $urandom_range(0, 1);
            cfg_irq_en = $urandom_range(0, 1);
            r = $urandom_range(0, 99);
            ev_valid = (r < 60);
            ev_code = (r < 35) ? TCODE : (r < 40) ? SCODE : 8'($urandom);
            carrier_en = $urandom_range(0, 1);
            trig = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0;
            rd_ack = ($urandom_range(0, 7) == 0);
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule